// File: doc/BRIEF.md
# Urgency-Ordered Arbiter with Rotating Tie-Break

This block decides which of several initiator ports may use a single shared target in a given cycle. Each port presents a request flag and a 3-bit urgency code. The smallest code is the most urgent, so code 0 wins over every other code. Code 7 is the least urgent, and a port with no specific setting should drive 7. The arbiter always serves the most urgent level that has a request pending. When several ports are pending at that level, it hands the grant among them in rotating order.

Each urgency level has its own rotation pointer. A pointer moves only when a transfer at its level completes, which means the granted port is asserting its request while the target is ready. Once a port holds the grant, it keeps it until its transfer completes or it withdraws its request, even if a more urgent request appears in the meantime. The grant is given both as a one-hot vector and as a binary index, and the index can drive a data multiplexer outside the block.

Top module: `prio_rr_arbiter`

## Requirements
- R1: When no request is pending, grant_valid is 0 and grant_onehot is all zeros.
- R2: A fresh grant goes to a pending port whose urgency code is the smallest among all pending ports. Lower codes are more urgent.
- R3: Code 0 is the most urgent level and code 7 the least urgent. A single request at code 0 wins over any number of requests at code 7.
- R4: Among pending ports that tie at the winning code, the grant goes to the first port at or after that level's rotation pointer, searching in increasing index order and wrapping from port 3 to port 0.
- R5: A level's pointer becomes (granted index + 1) mod 4 only on a completed transfer, meaning grant_valid and tgt_ready are both 1. Without that handshake it does not change.
- R6: Each of the 8 levels has its own pointer. A transfer at one level leaves the pointers of all other levels unchanged.
- R7: If a granted port is not accepted, the next cycle grants the same index for as long as that port keeps requesting, even if more urgent requests arrive.
- R8: If a held port drops its request, the arbiter re-arbitrates among the remaining requests in that same cycle.
- R9: grant_onehot has at most one bit set, and that bit is the one at grant_idx. req_ready equals grant_onehot when tgt_ready is 1 and is all zeros otherwise.
- R10: Reset clears every rotation pointer to port 0 and releases any held grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 4 | Request flag, one bit per port |
| req_prio | input | 12 | Urgency code for each port; port i occupies bits [3i+2:3i] |
| req_ready | output | 4 | Per-port acceptance (grant AND target ready) |
| tgt_ready | input | 1 | Target can take the granted transfer this cycle |
| grant_valid | output | 1 | Some port is granted |
| grant_onehot | output | 4 | One-hot grant vector |
| grant_idx | output | 2 | Binary index of the granted port |

## Verification
The bound checker evaluates several properties on every cycle. It checks that the grant is idle when nothing is requested and that the one-hot and index outputs agree. For any grant that is not a held grant, it checks that no more urgent request was passed over. It also checks that an unaccepted grant stays on the same port while that port keeps requesting, and that the pointer bank changes only on a completed handshake. The rotation order within a level cannot be checked cycle by cycle, because the checker has no independent model of it. The bench's vector walk covers that order, together with the independence of the per-level pointers, re-arbitration after a held port withdraws, and the pointer state after reset.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Next rotation start after serving port idx among n ports.
  function automatic int rr_step(int idx, int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Rotating candidate: offset k from start, wrapped into n ports.
  function automatic int rr_cand(int start, int k, int n);
    int c;
    c = start + k;
    if (c >= n) c = c - n;
    return c;
  endfunction

  // Lower code means more urgent.
  function automatic bit more_urgent(int a, int b);
    return a < b;
  endfunction
endpackage

// File: rtl/arb_level_scan.sv
module arb_level_scan #(
  parameter int NPORTS = 4,
  parameter int PRIO_W = 3
) (
  input  logic [NPORTS-1:0]        req_valid,
  input  logic [NPORTS*PRIO_W-1:0] req_prio,
  output logic [PRIO_W-1:0]        top_lvl,
  output logic [NPORTS-1:0]        tie_mask
);
  import arb_pkg::*;

  always_comb begin
    top_lvl = '1;
    for (int i = 0; i < NPORTS; i++) begin
      if (req_valid[i] &&
          more_urgent(int'(req_prio[i*PRIO_W +: PRIO_W]), int'(top_lvl)))
        top_lvl = req_prio[i*PRIO_W +: PRIO_W];
    end
  end

  always_comb begin
    for (int i = 0; i < NPORTS; i++)
      tie_mask[i] = req_valid[i] && (req_prio[i*PRIO_W +: PRIO_W] == top_lvl);
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NPORTS = 4,
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic [NPORTS-1:0] cand_mask,
  input  logic [IDX_W-1:0]  start_ptr,
  output logic              found,
  output logic [IDX_W-1:0]  pick_idx
);
  import arb_pkg::*;

  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int k = 0; k < NPORTS; k++) begin
      int c;
      c = rr_cand(int'(start_ptr), k, NPORTS);
      if (!found && cand_mask[c]) begin
        found    = 1'b1;
        pick_idx = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/arb_ptr_bank.sv
module arb_ptr_bank #(
  parameter int NPORTS = 4,
  parameter int PRIO_W = 3,
  localparam int IDX_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int NLEVELS = 1 << PRIO_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic [PRIO_W-1:0]        adv_lvl,
  input  logic [IDX_W-1:0]         adv_idx,
  output logic [NLEVELS*IDX_W-1:0] ptr_flat
);
  import arb_pkg::*;

  for (genvar l = 0; l < NLEVELS; l++) begin : g_lvl
    logic [IDX_W-1:0] ptr_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr_q <= '0;
      else if (adv && (adv_lvl == PRIO_W'(l)))
        ptr_q <= IDX_W'(rr_step(int'(adv_idx), NPORTS));
    end
    assign ptr_flat[l*IDX_W +: IDX_W] = ptr_q;
  end
endmodule

// File: rtl/prio_rr_arbiter.sv
module prio_rr_arbiter #(
  parameter int NPORTS = 4,
  parameter int PRIO_W = 3,
  localparam int IDX_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int NLEVELS = 1 << PRIO_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS-1:0]        req_valid,
  input  logic [NPORTS*PRIO_W-1:0] req_prio,
  output logic [NPORTS-1:0]        req_ready,
  input  logic                     tgt_ready,
  output logic                     grant_valid,
  output logic [NPORTS-1:0]        grant_onehot,
  output logic [IDX_W-1:0]         grant_idx
);
  // Named internal events, observed by the bound checker.
  logic [PRIO_W-1:0]        top_lvl;
  logic [NPORTS-1:0]        tie_mask;
  logic [NLEVELS*IDX_W-1:0] ptr_flat;
  logic [IDX_W-1:0]         cur_ptr;
  logic                     pick_found;
  logic [IDX_W-1:0]         pick_idx;
  logic                     lock_q;
  logic [IDX_W-1:0]         lock_idx_q;
  logic                     lock_hit;
  logic                     accept;
  logic [PRIO_W-1:0]        grant_lvl;

  arb_level_scan #(.NPORTS(NPORTS), .PRIO_W(PRIO_W)) u_scan (
    .req_valid (req_valid),
    .req_prio  (req_prio),
    .top_lvl   (top_lvl),
    .tie_mask  (tie_mask)
  );

  assign cur_ptr = ptr_flat[int'(top_lvl)*IDX_W +: IDX_W];

  arb_rr_pick #(.NPORTS(NPORTS)) u_pick (
    .cand_mask (tie_mask),
    .start_ptr (cur_ptr),
    .found     (pick_found),
    .pick_idx  (pick_idx)
  );

  // A held grant survives only while its owner keeps requesting.
  assign lock_hit = lock_q && req_valid[lock_idx_q];

  always_comb begin
    if (lock_hit) begin
      grant_valid = 1'b1;
      grant_idx   = lock_idx_q;
    end else begin
      grant_valid = pick_found;
      grant_idx   = pick_idx;
    end
  end

  always_comb begin
    for (int i = 0; i < NPORTS; i++)
      grant_onehot[i] = grant_valid && (grant_idx == IDX_W'(i));
  end

  assign req_ready = grant_onehot & {NPORTS{tgt_ready}};
  assign accept    = grant_valid && tgt_ready;
  assign grant_lvl = req_prio[int'(grant_idx)*PRIO_W +: PRIO_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= grant_valid && !tgt_ready;
      lock_idx_q <= grant_idx;
    end
  end

  arb_ptr_bank #(.NPORTS(NPORTS), .PRIO_W(PRIO_W)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (accept),
    .adv_lvl  (grant_lvl),
    .adv_idx  (grant_idx),
    .ptr_flat (ptr_flat)
  );
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int NPORTS = 4,
  parameter int PRIO_W = 3,
  localparam int IDX_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int NLEVELS = 1 << PRIO_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPORTS-1:0]        req_valid,
  input logic [NPORTS*PRIO_W-1:0] req_prio,
  input logic                     tgt_ready,
  input logic                     grant_valid,
  input logic [NPORTS-1:0]        grant_onehot,
  input logic [IDX_W-1:0]         grant_idx,
  input logic                     lock_hit,
  input logic                     accept,
  input logic [NLEVELS*IDX_W-1:0] ptr_flat
);
  logic              live;
  logic              passed_over;
  logic [PRIO_W-1:0] gl;

  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  always_comb begin
    gl = req_prio[int'(grant_idx)*PRIO_W +: PRIO_W];
    passed_over = 1'b0;
    for (int i = 0; i < NPORTS; i++)
      if (req_valid[i] && (req_prio[i*PRIO_W +: PRIO_W] < gl))
        passed_over = 1'b1;
  end

  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> (!grant_valid && grant_onehot == '0));

  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_onehot) && (grant_valid == (grant_onehot != '0)));

  a_r9_index: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> grant_onehot[grant_idx]);

  a_r2_urgent: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !lock_hit) |-> !passed_over);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(grant_valid && !tgt_ready) && req_valid[$past(grant_idx)])
      |-> (grant_valid && grant_idx == $past(grant_idx)));

  a_r5_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(ptr_flat));
endmodule

bind prio_rr_arbiter arb_chk #(.NPORTS(NPORTS), .PRIO_W(PRIO_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_prio     (req_prio),
  .tgt_ready    (tgt_ready),
  .grant_valid  (grant_valid),
  .grant_onehot (grant_onehot),
  .grant_idx    (grant_idx),
  .lock_hit     (lock_hit),
  .accept       (accept),
  .ptr_flat     (ptr_flat)
);

// File: tb/tb_prio_rr_arbiter.sv
`timescale 1ns/1ps
module tb_prio_rr_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req_valid = '0;
  logic [11:0] req_prio = '1;
  logic [3:0]  req_ready;
  logic        tgt_ready = 1'b0;
  logic        grant_valid;
  logic [3:0]  grant_onehot;
  logic [1:0]  grant_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_rr_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
    .req_ready(req_ready), .tgt_ready(tgt_ready), .grant_valid(grant_valid),
    .grant_onehot(grant_onehot), .grant_idx(grant_idx)
  );

  // {tag[23:20], valid[19:16], p3, p2, p1, p0, rdy[3], exp_valid[2], exp_idx[1:0]}
  localparam int NV = 22;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1,  4'b0000, 3'd7,3'd7,3'd7,3'd7, 1'b1, 1'b0, 2'd0}, // R1 idle
    {4'd4,  4'b1111, 3'd7,3'd7,3'd7,3'd7, 1'b1, 1'b1, 2'd0}, // R4 tie rotation
    {4'd4,  4'b1111, 3'd7,3'd7,3'd7,3'd7, 1'b1, 1'b1, 2'd1}, // R4
    {4'd4,  4'b1111, 3'd7,3'd7,3'd7,3'd7, 1'b1, 1'b1, 2'd2}, // R4
    {4'd4,  4'b1111, 3'd7,3'd7,3'd7,3'd7, 1'b1, 1'b1, 2'd3}, // R4
    {4'd5,  4'b1111, 3'd7,3'd7,3'd7,3'd7, 1'b1, 1'b1, 2'd0}, // R5 wrap
    {4'd3,  4'b1111, 3'd7,3'd0,3'd7,3'd7, 1'b1, 1'b1, 2'd2}, // R3 zero wins
    {4'd2,  4'b1010, 3'd4,3'd7,3'd5,3'd7, 1'b1, 1'b1, 2'd3}, // R2 lower code
    {4'd4,  4'b1111, 3'd2,3'd2,3'd2,3'd2, 1'b0, 1'b1, 2'd0}, // R4 level 2 fresh
    {4'd7,  4'b1111, 3'd2,3'd2,3'd2,3'd2, 1'b0, 1'b1, 2'd0}, // R7 hold
    {4'd7,  4'b1111, 3'd0,3'd2,3'd2,3'd2, 1'b0, 1'b1, 2'd0}, // R7 hold vs urgent
    {4'd7,  4'b1111, 3'd0,3'd2,3'd2,3'd2, 1'b1, 1'b1, 2'd0}, // R7 accepted
    {4'd2,  4'b1111, 3'd0,3'd2,3'd2,3'd2, 1'b1, 1'b1, 2'd3}, // R2 urgent next
    {4'd5,  4'b0111, 3'd2,3'd2,3'd2,3'd2, 1'b1, 1'b1, 2'd1}, // R5 level 2 ptr=1
    {4'd4,  4'b0011, 3'd2,3'd2,3'd2,3'd2, 1'b0, 1'b1, 2'd0}, // R4 wrap search
    {4'd8,  4'b0010, 3'd2,3'd2,3'd2,3'd2, 1'b1, 1'b1, 2'd1}, // R8 drop rearb
    {4'd6,  4'b1111, 3'd7,3'd7,3'd7,3'd7, 1'b1, 1'b1, 2'd1}, // R6 level 7 own ptr
    {4'd1,  4'b0000, 3'd7,3'd7,3'd7,3'd7, 1'b1, 1'b0, 2'd0}, // R1
    {4'd4,  4'b1001, 3'd7,3'd7,3'd7,3'd7, 1'b0, 1'b1, 2'd3}, // R4 from ptr 2
    {4'd1,  4'b0000, 3'd7,3'd7,3'd7,3'd7, 1'b0, 1'b0, 2'd0}, // R1 drop
    {4'd5,  4'b1001, 3'd7,3'd7,3'd7,3'd7, 1'b1, 1'b1, 2'd3}, // R5 no advance
    {4'd9,  4'b1001, 3'd7,3'd7,3'd7,3'd7, 1'b1, 1'b1, 2'd0}  // R9 ready mirror
  };

  task automatic check(int tag, bit ev, logic [1:0] ei, bit rdy);
    logic [3:0] exp_oh;
    logic [3:0] exp_rdy;
    bit ok;
    exp_oh  = ev ? (4'b0001 << ei) : 4'b0000;
    exp_rdy = rdy ? exp_oh : 4'b0000;
    ok = (grant_valid == ev) && (grant_onehot == exp_oh) && (req_ready == exp_rdy)
         && (!ev || grant_idx == ei);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d: got valid=%0b idx=%0d onehot=%b ready=%b, expected valid=%0b idx=%0d onehot=%b ready=%b",
               tag, grant_valid, grant_idx, grant_onehot, req_ready, ev, ei, exp_oh, exp_rdy);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL R1: watchdog expired, got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check(1, 1'b0, 2'd0, 1'b0); // R1 reset state, nothing requested
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      req_valid = VEC[v][19:16];
      req_prio  = VEC[v][15:4];
      tgt_ready = VEC[v][3];
      #1 check(int'(VEC[v][23:20]), VEC[v][2], VEC[v][1:0], VEC[v][3]);
    end
    // R10: level 7 pointer is 1 here; a held grant is also pending
    @(negedge clk);
    req_valid = 4'b1111; req_prio = '1; tgt_ready = 1'b0;
    #1 check(10, 1'b1, 2'd1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 4'b0110; tgt_ready = 1'b1;
    #1 check(10, 1'b1, 2'd1, 1'b1); // R10 lock released, ptr 0 -> port 1
    @(negedge clk);
    req_valid = 4'b1111;
    #1 check(10, 1'b1, 2'd2, 1'b1); // R10 ptr now 2
    @(negedge clk);
    req_valid = 4'b1111; req_prio = {3'd7, 3'd7, 3'd7, 3'd1}; tgt_ready = 1'b0;
    #1 check(3, 1'b1, 2'd0, 1'b0); // R3 single code-1 beats code 7
    @(negedge clk);
    req_valid = 4'b0000;
    #1 check(1, 1'b0, 2'd0, 1'b0); // R1
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule